// File: doc/BRIEF.md
# Real-Time Clock Register Front End

This block sits between a byte-oriented processor bus and a calendar timekeeper. It decodes a small address space of 4-byte-aligned registers. Some of them pass straight through to the timekeeper: the seven current-time bytes are read from input ports, and writes to them leave as a strobe. Others are held here: six alarm bytes, control, interrupt enables, two compensation bytes and an oscillator byte. A status byte gathers event flags from the timekeeper.

Writes are protected by a lock. A fixed 32-bit key must go to the first key register, and then a second fixed key to the second key register, before any other register accepts a write. Writing zero to the first key register locks the block again. Reads are never blocked.

The status register carries a BUSY bit for the window around each once-per-second calendar update, which is when software must not touch the time registers. It also carries a sticky power-up flag and an alarm flag, both cleared by writing a one to the bit. There are two level interrupt outputs, one for the alarm and one for the periodic per-second timer.

Top module: `rtc_regif`

## Requirements
- R1: After reset the block is locked, status reads 0x80 (power-up flag only), control, interrupt enable, alarm, compensation and oscillator registers read 0, and both interrupt outputs are low.
- R2: Writing KEY0 (0x83E70B13) to offset 0x6C and then KEY1 (0x95A4F1E0) to offset 0x70 unlocks writes. Writing 0 to offset 0x6C locks them again.
- R3: KEY1 without a directly preceding KEY0 write, or a wrong value at either key register, leaves the block locked.
- R4: While locked, writes to every offset other than the two key registers change nothing. This includes the time strobe and the status flags. Reads work normally.
- R5: Offsets 0x00 to 0x18 (seconds, minutes, hours, day, month, year, week; byte i at offset 4*i) read the matching byte of cal_time_i. An unlocked write there raises tm_wr_o in the same cycle, with tm_idx_o = offset/4 and tm_data_o = the low data byte.
- R6: Offsets 0x20 to 0x34 hold the six alarm bytes (byte i at 0x20+4*i). They read back and appear on alarm_bcd_o bits [8i+7:8i].
- R7: Offset 0x40 is the control byte (bit0 = run), driven on ctrl_o. Status bit1 mirrors control bit0.
- R8: Status at 0x44 is laid out as bit7 power-up, bit6 alarm, bit5 day, bit4 hour, bit3 minute, bit2 second, bit1 run, bit0 busy. Writing 1 to bit7 or bit6 clears that flag. Writing the other bits has no effect.
- R9: An alarm_match_i pulse sets the alarm flag on the next edge. When it coincides with a clearing write, the flag ends up set.
- R10: tick_sec_i, tick_min_i, tick_hour_i and tick_day_i each set their status flag. All four flags clear when upd_warn_i opens the next update window.
- R11: BUSY rises the edge after upd_warn_i and falls the edge after tick_sec_i.
- R12: Offset 0x48 holds the enables: bit3 for the alarm and bit2 for the timer; other bits read 0. irq_alarm_o is the alarm flag AND bit3, and irq_timer_o is the second flag AND bit2. Both are levels.
- R13: Offsets 0x4C and 0x50 (compensation low and high) and 0x54 (oscillator) read back what was written and drive comp_o and osc_o. Unmapped offsets and the key registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low reset |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_addr_i | input | 8 | Byte offset |
| bus_wdata_i | input | 32 | Write data (keys use all 32 bits, registers the low byte) |
| bus_rdata_o | output | 8 | Read data for bus_addr_i, combinational |
| cal_time_i | input | 56 | Current calendar bytes from the timekeeper, seconds in the low byte |
| tm_wr_o | output | 1 | Time byte write strobe toward the timekeeper |
| tm_idx_o | output | 3 | Index of the time byte being written |
| tm_data_o | output | 8 | Time byte value being written |
| alarm_bcd_o | output | 48 | Alarm bytes toward the comparator |
| alarm_match_i | input | 1 | Alarm comparator hit pulse |
| upd_warn_i | input | 1 | Pulse marking the start of an update window |
| tick_sec_i | input | 1 | Second rollover pulse, which also ends the window |
| tick_min_i | input | 1 | Minute rollover pulse |
| tick_hour_i | input | 1 | Hour rollover pulse |
| tick_day_i | input | 1 | Day rollover pulse |
| ctrl_o | output | 8 | Control byte |
| comp_o | output | 16 | Compensation value, high byte from 0x50 |
| osc_o | output | 8 | Oscillator byte |
| irq_alarm_o | output | 1 | Alarm interrupt level |
| irq_timer_o | output | 1 | Per-second timer interrupt level |

## Verification
The bench builds the block with its default parameters: 32-bit write words, byte registers, seven time bytes, six alarm bytes and the two default keys. With these defaults the exact key values can be driven, which makes the correct sequence, each broken variant of it and the relock path all reachable in a few writes. Event, busy and alarm pulses are driven directly, so the bench can place each flag edge, including a set that collides with a clear, on a chosen cycle.

// File: rtl/rtc_regif_pkg.sv
package rtc_regif_pkg;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_WEEK    = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_ASEC    = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_AYEAR   = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_CTRL    = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_STATUS  = 8'h44;
  localparam logic [ADDR_W-1:0] OFS_IEN     = 8'h48;
  localparam logic [ADDR_W-1:0] OFS_COMP_LO = 8'h4C;
  localparam logic [ADDR_W-1:0] OFS_COMP_HI = 8'h50;
  localparam logic [ADDR_W-1:0] OFS_OSC     = 8'h54;
  localparam logic [ADDR_W-1:0] OFS_KEY_A   = 8'h6C;
  localparam logic [ADDR_W-1:0] OFS_KEY_B   = 8'h70;

  // status bit positions (software decodes these)
  localparam int ST_PWR   = 7;
  localparam int ST_ALARM = 6;
  localparam int ST_BUSY  = 0;
  // interrupt enable bit positions
  localparam int IE_ALARM = 3;
  localparam int IE_TIMER = 2;

  function automatic logic is_time(input logic [ADDR_W-1:0] a);
    return (a[1:0] == 2'b00) && (a <= OFS_WEEK);
  endfunction

  function automatic logic is_alarm(input logic [ADDR_W-1:0] a);
    return (a[1:0] == 2'b00) && (a >= OFS_ASEC) && (a <= OFS_AYEAR);
  endfunction

  // word index inside a bank of consecutive 4-byte registers
  function automatic logic [2:0] slot(input logic [ADDR_W-1:0] a);
    return a[4:2];
  endfunction
endpackage

// File: rtl/rtc_kick_lock.sv
module rtc_kick_lock #(
  parameter int WORD_W = 32,
  parameter logic [WORD_W-1:0] KEY0 = 32'h83E70B13,
  parameter logic [WORD_W-1:0] KEY1 = 32'h95A4F1E0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_key_a_i,
  input  logic              wr_key_b_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic              unlocked_o
);
  logic armed_q, open_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      open_q  <= 1'b0;
    end else if (wr_key_a_i) begin
      armed_q <= (wdata_i == KEY0);
      if (wdata_i == '0) open_q <= 1'b0;
    end else if (wr_key_b_i) begin
      if (armed_q && (wdata_i == KEY1)) open_q <= 1'b1;
      armed_q <= 1'b0;
    end
  end

  assign unlocked_o = open_q;
endmodule

// File: rtl/rtc_status_flags.sv
module rtc_status_flags (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_pwr_i,
  input  logic       clr_alarm_i,
  input  logic       alarm_match_i,
  input  logic       upd_warn_i,
  input  logic       tick_sec_i,
  input  logic       tick_min_i,
  input  logic       tick_hour_i,
  input  logic       tick_day_i,
  output logic       pwr_o,
  output logic       alarm_o,
  output logic [3:0] evt_o,   // {day, hour, min, sec}
  output logic       busy_o
);
  logic [3:0] ticks;
  assign ticks = {tick_day_i, tick_hour_i, tick_min_i, tick_sec_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_o   <= 1'b1;
      alarm_o <= 1'b0;
      evt_o   <= '0;
      busy_o  <= 1'b0;
    end else begin
      if (clr_pwr_i) pwr_o <= 1'b0;
      if (alarm_match_i)    alarm_o <= 1'b1;
      else if (clr_alarm_i) alarm_o <= 1'b0;
      evt_o <= (upd_warn_i ? 4'b0000 : evt_o) | ticks;
      if (tick_sec_i)      busy_o <= 1'b0;
      else if (upd_warn_i) busy_o <= 1'b1;
    end
  end
endmodule

// File: rtl/rtc_cfg_regs.sv
module rtc_cfg_regs import rtc_regif_pkg::*; #(
  parameter int BYTE_W  = 8,
  parameter int N_ALARM = 6,
  localparam int N_COMP = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [BYTE_W-1:0]         wdata_i,
  output logic [N_ALARM*BYTE_W-1:0] alarm_o,
  output logic [BYTE_W-1:0]         ctrl_o,
  output logic [1:0]                ien_o,   // {alarm, timer}
  output logic [N_COMP*BYTE_W-1:0]  comp_o,
  output logic [BYTE_W-1:0]         osc_o
);
  logic [BYTE_W-1:0] alm_q  [N_ALARM];
  logic [BYTE_W-1:0] comp_q [N_COMP];

  for (genvar g = 0; g < N_ALARM; g++) begin : g_alarm
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) alm_q[g] <= '0;
      else if (wr_i && is_alarm(addr_i) && (slot(addr_i) == 3'(g))) alm_q[g] <= wdata_i;
    end
    assign alarm_o[g*BYTE_W +: BYTE_W] = alm_q[g];
  end

  for (genvar c = 0; c < N_COMP; c++) begin : g_comp
    localparam logic [ADDR_W-1:0] OFS = OFS_COMP_LO + ADDR_W'(4 * c);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) comp_q[c] <= '0;
      else if (wr_i && (addr_i == OFS)) comp_q[c] <= wdata_i;
    end
    assign comp_o[c*BYTE_W +: BYTE_W] = comp_q[c];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '0;
      ien_o  <= '0;
      osc_o  <= '0;
    end else if (wr_i) begin
      if (addr_i == OFS_CTRL) ctrl_o <= wdata_i;
      if (addr_i == OFS_IEN)  ien_o  <= {wdata_i[IE_ALARM], wdata_i[IE_TIMER]};
      if (addr_i == OFS_OSC)  osc_o  <= wdata_i;
    end
  end
endmodule

// File: rtl/rtc_regif.sv
module rtc_regif import rtc_regif_pkg::*; #(
  parameter int WORD_W  = 32,
  parameter int BYTE_W  = 8,
  parameter int N_TIME  = 7,
  parameter int N_ALARM = 6,
  parameter logic [WORD_W-1:0] KEY0 = 32'h83E70B13,
  parameter logic [WORD_W-1:0] KEY1 = 32'h95A4F1E0
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      bus_wr_i,
  input  logic [ADDR_W-1:0]         bus_addr_i,
  input  logic [WORD_W-1:0]         bus_wdata_i,
  output logic [BYTE_W-1:0]         bus_rdata_o,
  input  logic [N_TIME*BYTE_W-1:0]  cal_time_i,
  output logic                      tm_wr_o,
  output logic [2:0]                tm_idx_o,
  output logic [BYTE_W-1:0]         tm_data_o,
  output logic [N_ALARM*BYTE_W-1:0] alarm_bcd_o,
  input  logic                      alarm_match_i,
  input  logic                      upd_warn_i,
  input  logic                      tick_sec_i,
  input  logic                      tick_min_i,
  input  logic                      tick_hour_i,
  input  logic                      tick_day_i,
  output logic [BYTE_W-1:0]         ctrl_o,
  output logic [2*BYTE_W-1:0]       comp_o,
  output logic [BYTE_W-1:0]         osc_o,
  output logic                      irq_alarm_o,
  output logic                      irq_timer_o
);
  // named internal events, also observed by the bound checker
  logic              unlocked;
  logic              reg_wr;
  logic              pwr_flag, alarm_flag, busy_flag;
  logic [3:0]        evt_flags;
  logic [1:0]        ien;
  logic [BYTE_W-1:0] wbyte;
  logic [7:0]        status_byte;

  assign wbyte  = bus_wdata_i[BYTE_W-1:0];
  assign reg_wr = bus_wr_i && unlocked;

  rtc_kick_lock #(.WORD_W(WORD_W), .KEY0(KEY0), .KEY1(KEY1)) u_lock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_key_a_i (bus_wr_i && (bus_addr_i == OFS_KEY_A)),
    .wr_key_b_i (bus_wr_i && (bus_addr_i == OFS_KEY_B)),
    .wdata_i    (bus_wdata_i),
    .unlocked_o (unlocked)
  );

  rtc_status_flags u_flags (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .clr_pwr_i     (reg_wr && (bus_addr_i == OFS_STATUS) && bus_wdata_i[ST_PWR]),
    .clr_alarm_i   (reg_wr && (bus_addr_i == OFS_STATUS) && bus_wdata_i[ST_ALARM]),
    .alarm_match_i (alarm_match_i),
    .upd_warn_i    (upd_warn_i),
    .tick_sec_i    (tick_sec_i),
    .tick_min_i    (tick_min_i),
    .tick_hour_i   (tick_hour_i),
    .tick_day_i    (tick_day_i),
    .pwr_o         (pwr_flag),
    .alarm_o       (alarm_flag),
    .evt_o         (evt_flags),
    .busy_o        (busy_flag)
  );

  rtc_cfg_regs #(.BYTE_W(BYTE_W), .N_ALARM(N_ALARM)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr),
    .addr_i  (bus_addr_i),
    .wdata_i (wbyte),
    .alarm_o (alarm_bcd_o),
    .ctrl_o  (ctrl_o),
    .ien_o   (ien),
    .comp_o  (comp_o),
    .osc_o   (osc_o)
  );

  // time writes are forwarded to the timekeeper
  assign tm_wr_o   = reg_wr && is_time(bus_addr_i);
  assign tm_idx_o  = slot(bus_addr_i);
  assign tm_data_o = wbyte;

  assign status_byte = {pwr_flag, alarm_flag, evt_flags, ctrl_o[0], busy_flag};

  always_comb begin
    bus_rdata_o = '0;
    if (is_time(bus_addr_i)) begin
      for (int i = 0; i < N_TIME; i++)
        if (slot(bus_addr_i) == 3'(i)) bus_rdata_o = cal_time_i[i*BYTE_W +: BYTE_W];
    end else if (is_alarm(bus_addr_i)) begin
      for (int i = 0; i < N_ALARM; i++)
        if (slot(bus_addr_i) == 3'(i)) bus_rdata_o = alarm_bcd_o[i*BYTE_W +: BYTE_W];
    end else begin
      case (bus_addr_i)
        OFS_CTRL:    bus_rdata_o = ctrl_o;
        OFS_STATUS:  bus_rdata_o = BYTE_W'(status_byte);
        OFS_IEN:     bus_rdata_o = BYTE_W'({ien, 2'b00});
        OFS_COMP_LO: bus_rdata_o = comp_o[BYTE_W-1:0];
        OFS_COMP_HI: bus_rdata_o = comp_o[2*BYTE_W-1:BYTE_W];
        OFS_OSC:     bus_rdata_o = osc_o;
        default:     bus_rdata_o = '0;
      endcase
    end
  end

  assign irq_alarm_o = alarm_flag   && ien[1];
  assign irq_timer_o = evt_flags[0] && ien[0];
endmodule

// File: rtl/rtc_regif_chk.sv
module rtc_regif_chk import rtc_regif_pkg::*; #(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8,
  parameter logic [WORD_W-1:0] KEY1 = 32'h95A4F1E0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_wr_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [WORD_W-1:0] bus_wdata_i,
  input logic              unlocked,
  input logic              pwr_flag,
  input logic              alarm_flag,
  input logic              busy_flag,
  input logic              alarm_match_i,
  input logic              tick_sec_i,
  input logic [BYTE_W-1:0] ctrl_o,
  input logic              irq_alarm_o
);
  AST_UNLOCK_NEEDS_KEY1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unlocked) |-> $past(bus_wr_i && bus_addr_i == OFS_KEY_B && bus_wdata_i == KEY1)); // R2

  AST_LOCKED_CTRL_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unlocked && bus_wr_i && bus_addr_i == OFS_CTRL) |=> $stable(ctrl_o)); // R4

  AST_PWR_CLEAR_BY_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwr_flag) |-> $past(bus_wr_i && unlocked && bus_addr_i == OFS_STATUS && bus_wdata_i[ST_PWR])); // R8

  AST_ALARM_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_match_i |=> alarm_flag); // R9

  AST_BUSY_ENDS_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_flag) |-> $past(tick_sec_i)); // R11

  AST_IRQ_ALARM_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_alarm_o |-> alarm_flag); // R12
endmodule

bind rtc_regif rtc_regif_chk #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .KEY1(KEY1)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .bus_wr_i      (bus_wr_i),
  .bus_addr_i    (bus_addr_i),
  .bus_wdata_i   (bus_wdata_i),
  .unlocked      (unlocked),
  .pwr_flag      (pwr_flag),
  .alarm_flag    (alarm_flag),
  .busy_flag     (busy_flag),
  .alarm_match_i (alarm_match_i),
  .tick_sec_i    (tick_sec_i),
  .ctrl_o        (ctrl_o),
  .irq_alarm_o   (irq_alarm_o)
);

// File: tb/rtc_regif_tb.sv
module rtc_regif_tb;
  localparam logic [31:0] K0 = 32'h83E70B13;
  localparam logic [31:0] K1 = 32'h95A4F1E0;
  localparam logic [55:0] CAL = 56'h03_24_12_31_23_59_58;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [7:0]  rdata;
  logic        tm_wr;
  logic [2:0]  tm_idx;
  logic [7:0]  tm_data;
  logic [47:0] alarm_bcd;
  logic        amatch = 1'b0, warn = 1'b0;
  logic        tsec = 1'b0, tmin = 1'b0, thour = 1'b0, tday = 1'b0;
  logic [7:0]  ctrl, osc;
  logic [15:0] comp;
  logic        irq_a, irq_t;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  rtc_regif u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .cal_time_i(CAL),
    .tm_wr_o(tm_wr), .tm_idx_o(tm_idx), .tm_data_o(tm_data),
    .alarm_bcd_o(alarm_bcd), .alarm_match_i(amatch), .upd_warn_i(warn),
    .tick_sec_i(tsec), .tick_min_i(tmin), .tick_hour_i(thour), .tick_day_i(tday),
    .ctrl_o(ctrl), .comp_o(comp), .osc_o(osc),
    .irq_alarm_o(irq_a), .irq_timer_o(irq_t)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic bw(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic rchk(input string req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic unlock();
    bw(8'h6C, K0); bw(8'h70, K1);
  endtask

  task automatic t_reset();
    rchk("R1 status", 8'h44, 8'h80);
    rchk("R1 ctrl", 8'h40, 8'h00);
    rchk("R1 ien", 8'h48, 8'h00);
    chk("R1 irqs", {irq_a, irq_t}, 2'b00);
    chk("R1 alarm/comp/osc", {alarm_bcd, comp, osc}, '0);
  endtask

  task automatic t_locked();
    bw(8'h40, 32'h01);
    rchk("R4 ctrl locked", 8'h40, 8'h00);
    bw(8'h20, 32'h11);
    chk("R4 alarm locked", alarm_bcd[7:0], 8'h00);
    bw(8'h44, 32'hC0);
    rchk("R4 status locked", 8'h44, 8'h80);
    @(negedge clk); wr = 1'b1; addr = 8'h04; wdata = 32'h12;
    #1 chk("R4 no time strobe", tm_wr, 1'b0);
    @(negedge clk); wr = 1'b0;
    rchk("R4 read while locked", 8'h04, 8'h59);
  endtask

  task automatic t_bad_keys();
    bw(8'h70, K1);
    bw(8'h40, 32'h01);
    rchk("R3 key1 alone", 8'h40, 8'h00);
    bw(8'h6C, K0); bw(8'h70, 32'h1234); bw(8'h70, K1);
    bw(8'h40, 32'h01);
    rchk("R3 wrong key1", 8'h40, 8'h00);
    bw(8'h6C, K0 ^ 32'h1); bw(8'h70, K1);
    bw(8'h40, 32'h01);
    rchk("R3 wrong key0", 8'h40, 8'h00);
  endtask

  task automatic t_unlock_ctrl();
    unlock();
    bw(8'h40, 32'h05);
    rchk("R2 ctrl after unlock", 8'h40, 8'h05);
    chk("R7 ctrl_o", ctrl, 8'h05);
    rchk("R7 run mirrored", 8'h44, 8'h82);
  endtask

  task automatic t_time();
    @(negedge clk); wr = 1'b1; addr = 8'h0C; wdata = 32'hAB17;
    #1 chk("R5 time strobe", {tm_wr, tm_idx, tm_data}, {1'b1, 3'd3, 8'h17});
    @(negedge clk); wr = 1'b0;
    for (int i = 0; i < 7; i++) rchk("R5 time read", 8'(4 * i), CAL[8*i +: 8]);
  endtask

  task automatic t_alarm();
    for (int i = 0; i < 6; i++) bw(8'(8'h20 + 4 * i), 32'(8'hA0 + i));
    for (int i = 0; i < 6; i++) rchk("R6 alarm read", 8'(8'h20 + 4 * i), 8'(8'hA0 + i));
    chk("R6 alarm_bcd", alarm_bcd, 48'hA5A4A3A2A1A0);
  endtask

  task automatic t_misc();
    bw(8'h4C, 32'h12); bw(8'h50, 32'h34); bw(8'h54, 32'h56);
    rchk("R13 comp lo", 8'h4C, 8'h12);
    rchk("R13 comp hi", 8'h50, 8'h34);
    rchk("R13 osc", 8'h54, 8'h56);
    chk("R13 outputs", {comp, osc}, 24'h341256);
    rchk("R13 unmapped", 8'h3C, 8'h00);
    rchk("R13 key reads 0", 8'h6C, 8'h00);
  endtask

  task automatic t_w1c();
    bw(8'h44, 32'h3F);
    rchk("R8 other bits ignored", 8'h44, 8'h82);
    pulse(amatch);
    rchk("R9 alarm set", 8'h44, 8'hC2);
    bw(8'h44, 32'h40);
    rchk("R8 alarm cleared", 8'h44, 8'h82);
    bw(8'h44, 32'h80);
    rchk("R8 power-up cleared", 8'h44, 8'h02);
    @(negedge clk); amatch = 1'b1; wr = 1'b1; addr = 8'h44; wdata = 32'h40;
    @(negedge clk); amatch = 1'b0; wr = 1'b0;
    rchk("R9 set beats clear", 8'h44, 8'h42);
  endtask

  task automatic t_events_busy();
    pulse(warn);
    rchk("R11 busy up", 8'h44, 8'h43);
    pulse(tsec);
    rchk("R11 busy down R10 sec", 8'h44, 8'h46);
    pulse(tmin); pulse(thour); pulse(tday);
    rchk("R10 all events", 8'h44, 8'h7E);
    pulse(warn);
    rchk("R10 cleared at window", 8'h44, 8'h43);
    pulse(tsec);
  endtask

  task automatic t_irq();
    bw(8'h48, 32'hFF);
    rchk("R12 ien read", 8'h48, 8'h0C);
    @(negedge clk); chk("R12 irq both", {irq_a, irq_t}, 2'b11);
    bw(8'h48, 32'h04);
    @(negedge clk); chk("R12 alarm gated", {irq_a, irq_t}, 2'b01);
    pulse(warn);
    @(negedge clk); chk("R12 timer level ends", irq_t, 1'b0);
    pulse(tsec);
    bw(8'h48, 32'h00);
    @(negedge clk); chk("R12 disabled", {irq_a, irq_t}, 2'b00);
  endtask

  task automatic t_relock();
    bw(8'h6C, 32'h0);
    bw(8'h40, 32'h00);
    rchk("R2 relocked", 8'h40, 8'h05);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_locked();
    t_bad_keys();
    t_unlock_ctrl();
    t_time();
    t_alarm();
    t_misc();
    t_w1c();
    t_events_busy();
    t_irq();
    t_relock();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule